// File: doc/BRIEF.md
# Four-Instruction Accumulator Processor

This block is a very small processor built around a single 16-bit accumulator and a 14-bit program counter. It executes programs held in a word-wide memory of 16K locations, where each 16-bit word is either data or an instruction. An instruction has a 2-bit operation code in its top two bits and a 14-bit memory address in its low fourteen bits.

The four operations are:

- load a word into the accumulator;
- store the accumulator;
- add a word to the accumulator;
- jump when the accumulator is negative.

The branch tests accumulator bit 15 directly. There is no flag register.

Every instruction takes three clock cycles: fetch, decode and execute.

Two registers sit between the datapath and memory. A hidden address register drives the memory address. A hidden buffer register holds the store data. Neither can be reached by a program.

The memory write is taken on a rising clock edge. The read data returns combinationally from the registered address.

Two debug outputs show the program counter and the accumulator, so that a reference model can follow the program.

Top module: `acc_cpu`

## Requirements
- R1: While reset (active low) is held, and after it is released, the program counter and accumulator read zero, the write enable is low, and the memory address is zero.
- R2: Each instruction occupies exactly three cycles. In the first cycle the memory address equals the program counter. After that cycle's edge the program counter has advanced by one, wrapping within 14 bits.
- R3: Operation code 00 (bits 15:14) puts the memory word at the operand address (bits 13:0) into the accumulator. The address is shown during the third cycle.
- R4: Operation code 01 writes the accumulator to the operand address during the third cycle, and leaves the accumulator unchanged.
- R5: Operation code 10 adds the word at the operand address to the accumulator, modulo 2^16, with no carry kept.
- R6: Operation code 11 with accumulator bit 15 set loads the operand address into the program counter. The next fetch reads from that address.
- R7: Operation code 11 with accumulator bit 15 clear leaves the program counter at the following instruction.
- R8: The write enable is high only in the third cycle of a store, for exactly one cycle, and never for any other operation.
- R9: Sequential execution from address 0x3FFF continues at address 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | 14 | Word address to memory (hidden address register) |
| mem_wdata | output | 16 | Write data (hidden buffer register) |
| mem_rdata | input | 16 | Read data for the word at mem_addr |
| mem_we | output | 1 | Write enable, taken on the rising edge |
| dbg_pc | output | 14 | Current program counter |
| dbg_acc | output | 16 | Current accumulator |

## Verification
Each instruction's effects fall at fixed points in its three-cycle window:

- the fetch address is valid in the first cycle;
- the operand address, and any write, are valid in the third cycle;
- the new program counter and accumulator appear after the third rising edge.

The bench drives and samples only on falling edges. It walks each instruction through its three phases and checks the memory-side signals in the phase where they are due. After the third edge it compares the debug outputs with a bench model that has stepped the same instruction. Random programs over a mirrored memory cover both branch outcomes broadly. A directed program pins down additive wrap, a taken and an untaken branch, the program-counter wrap at 0x3FFF, and a store read back by a later load.

// File: rtl/acc_cpu.sv
module acc_cpu #(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [AW-1:0] dbg_pc,
  output logic [DW-1:0] dbg_acc
);
  localparam int OW = DW - AW;
  localparam logic [1:0] S_FETCH  = 2'd0;
  localparam logic [1:0] S_DECODE = 2'd1;
  localparam logic [1:0] S_EXEC   = 2'd2;
  localparam logic [OW-1:0] OP_LD  = OW'(0);
  localparam logic [OW-1:0] OP_ST  = OW'(1);
  localparam logic [OW-1:0] OP_ADD = OW'(2);
  localparam logic [OW-1:0] OP_BRN = OW'(3);

  logic [1:0]    state;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] acc, ir, mbr;
  logic [OW-1:0] op;
  logic [AW-1:0] opnd;
  logic          taken;

  assign op    = ir[DW-1 -: OW];
  assign opnd  = ir[AW-1:0];
  assign taken = (op == OP_BRN) && acc[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_FETCH;
      pc    <= '0;
      acc   <= '0;
      ir    <= '0;
      mar   <= '0;
      mbr   <= '0;
    end else begin
      case (state)
        S_FETCH: begin
          ir    <= mem_rdata;
          pc    <= pc + AW'(1);
          state <= S_DECODE;
        end
        S_DECODE: begin
          mar   <= opnd;
          mbr   <= acc;
          state <= S_EXEC;
        end
        S_EXEC: begin
          case (op)
            OP_LD:   acc <= mem_rdata;
            OP_ADD:  acc <= acc + mem_rdata;
            default: ;
          endcase
          if (taken) pc <= opnd;
          mar   <= taken ? opnd : pc;
          state <= S_FETCH;
        end
        default: state <= S_FETCH;
      endcase
    end
  end

  assign mem_addr  = mar;
  assign mem_wdata = mbr;
  assign mem_we    = (state == S_EXEC) && (op == OP_ST);
  assign dbg_pc    = pc;
  assign dbg_acc   = acc;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
  parameter int AW = 14,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    state,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc,
  input logic [DW-1:0] ir,
  input logic          mem_we
);
  p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 |=> state == 2'd1);
  p_seq_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd1 |=> state == 2'd2);
  p_seq_exec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd2 |=> state == 2'd0);
  p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == 2'd0 |=> pc == $past(pc) + AW'(1));
  p_store_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && ir[DW-1 -: 2] == 2'b01) |=> $stable(acc));
  p_branch_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && ir[DW-1 -: 2] == 2'b11 && acc[DW-1]) |=> pc == $past(ir[AW-1:0]));
  p_branch_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2 && ir[DW-1 -: 2] == 2'b11 && !acc[DW-1]) |=> $stable(pc));
  p_we_store_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state == 2'd2 && ir[DW-1 -: 2] == 2'b01));
  p_we_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);
endmodule

bind acc_cpu acc_cpu_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .pc(pc), .acc(acc), .ir(ir), .mem_we(mem_we)
);

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  localparam int MW = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [13:0] mem_addr, dbg_pc;
  logic [15:0] mem_wdata, mem_rdata, dbg_acc;
  logic mem_we;

  logic [15:0] mem     [0:(1<<MW)-1];
  logic [15:0] ref_mem [0:(1<<MW)-1];
  logic [13:0] ref_pc;
  logic [15:0] ref_acc;
  int checks = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .dbg_pc(dbg_pc), .dbg_acc(dbg_acc)
  );

  assign mem_rdata = mem[mem_addr[MW-1:0]];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic memw();
    if (mem_we) mem[mem_addr[MW-1:0]] = mem_wdata;
  endtask

  task automatic poke(input int a, input logic [15:0] d);
    mem[a[MW-1:0]] = d;
    ref_mem[a[MW-1:0]] = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dbg_pc == 14'd0, "R1 pc", 32'(dbg_pc), 0);
    chk(dbg_acc == 16'd0, "R1 acc", 32'(dbg_acc), 0);
    chk(mem_we == 1'b0, "R1 we", 32'(mem_we), 0);
    chk(mem_addr == 14'd0, "R1 addr", 32'(mem_addr), 0);
    ref_pc = '0;
    ref_acc = '0;
    rst_n = 1'b1;
  endtask

  task automatic step();
    logic [15:0] ins;
    logic [1:0] op;
    logic [13:0] a;
    ins = ref_mem[ref_pc[MW-1:0]];
    op = ins[15:14];
    a = ins[13:0];
    chk(mem_addr == ref_pc, "R2 fetch addr", 32'(mem_addr), 32'(ref_pc));
    chk(mem_we == 1'b0, "R8 fetch we", 32'(mem_we), 0);
    memw();
    @(posedge clk); @(negedge clk);
    chk(dbg_pc == ref_pc + 14'd1, "R2 pc step", 32'(dbg_pc), 32'(ref_pc + 14'd1));
    chk(mem_we == 1'b0, "R8 decode we", 32'(mem_we), 0);
    memw();
    @(posedge clk); @(negedge clk);
    if (op == 2'b01) begin
      chk(mem_we == 1'b1, "R4 store we", 32'(mem_we), 1);
      chk(mem_addr == a, "R4 store addr", 32'(mem_addr), 32'(a));
      chk(mem_wdata == ref_acc, "R4 store data", 32'(mem_wdata), 32'(ref_acc));
    end else begin
      chk(mem_we == 1'b0, "R8 exec we", 32'(mem_we), 0);
      if (op != 2'b11) chk(mem_addr == a, "R3 operand addr", 32'(mem_addr), 32'(a));
    end
    memw();
    @(posedge clk); @(negedge clk);
    ref_pc = ref_pc + 14'd1;
    case (op)
      2'b00: ref_acc = ref_mem[a[MW-1:0]];
      2'b01: ref_mem[a[MW-1:0]] = ref_acc;
      2'b10: ref_acc = ref_acc + ref_mem[a[MW-1:0]];
      default: if (ref_acc[15]) ref_pc = a;
    endcase
    chk(dbg_pc == ref_pc, op == 2'b11 ? (ref_acc[15] ? "R6 pc" : "R7 pc") : "R2 pc",
        32'(dbg_pc), 32'(ref_pc));
    chk(dbg_acc == ref_acc, op == 2'b10 ? "R5 acc" : (op == 2'b01 ? "R4 acc" : "R3 acc"),
        32'(dbg_acc), 32'(ref_acc));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        checks++;
        bad++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < (1 << MW); i++) poke(i, 16'h0000);
    poke(0, 16'h0200);
    poke(1, 16'hC050);
    poke(2, 16'h8201);
    poke(3, 16'hFFFE);
    poke(16'h3FE, 16'h8202);
    poke(16'h3FF, 16'h4203);
    poke(16'h200, 16'h7FFF);
    poke(16'h201, 16'h0001);
    poke(16'h202, 16'h8001);
    @(negedge clk);
    do_reset();
    step();
    chk(dbg_acc == 16'h7FFF, "R3 directed load", 32'(dbg_acc), 32'h7FFF);
    step();
    chk(dbg_pc == 14'd2, "R7 directed untaken", 32'(dbg_pc), 2);
    step();
    chk(dbg_acc == 16'h8000, "R5 directed add", 32'(dbg_acc), 32'h8000);
    step();
    chk(dbg_pc == 14'h3FFE, "R6 directed taken", 32'(dbg_pc), 32'h3FFE);
    step();
    chk(dbg_acc == 16'h0001, "R5 directed wrap", 32'(dbg_acc), 1);
    step();
    chk(dbg_pc == 14'h0000, "R9 pc wrap", 32'(dbg_pc), 0);
    chk(mem[16'h203] == 16'h0001, "R4 stored word", 32'(mem[16'h203]), 1);
    poke(0, 16'h0203);
    step();
    chk(dbg_acc == 16'h0001, "R3 load back", 32'(dbg_acc), 1);

    for (int i = 0; i < (1 << MW); i++) poke(i, 16'($urandom));
    do_reset();
    for (int n = 0; n < 400; n++) step();

    for (int i = 0; i < (1 << MW); i++) poke(i, {i[0] ? 2'b11 : 2'($urandom), 14'($urandom)});
    do_reset();
    for (int n = 0; n < 400; n++) step();

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule